// File: doc/BRIEF.md
# Prefetch Issue Filter with In-Flight Tracking

This block sits between a prefetch candidate generator and the memory request path. Each cycle it may receive one candidate line address, together with three lookup results for that line that the surrounding logic supplies in the same cycle: presence in the second-level cache, presence in the first-level cache, and a match in the demand-miss tracker. The block also searches its own table of prefetches already sent but not yet completed. A candidate that hits in any of these four places is dropped. A candidate that finds the table at capacity is dropped too, so the table size caps prefetch bandwidth. A surviving candidate is issued to memory and stored in a free slot of the table.

A completion input reports a line that has arrived in a cache. Every table entry holding that line is released, and the slot can be reused from the next cycle. Each candidate gets one response, one cycle later, that says whether it was issued and, if not, why. The generator uses this response to track the last address it issued.

Occupancy is tracked by a three-state machine. `OCC_IDLE` means the table is empty. `OCC_PART` means it holds some entries. `OCC_CAP` means every slot is taken. The transitions are:
- `OCC_IDLE` to `OCC_PART` on an issue. This goes straight to `OCC_CAP` when the depth is one.
- `OCC_PART` to `OCC_CAP` on an issue that fills the last slot.
- `OCC_PART` to `OCC_IDLE` on a release of the only entry.
- `OCC_CAP` to `OCC_PART` on a release.

All other cases hold the state. `OCC_CAP` is the condition that blocks new issues.

Top module: `pf_issue_filter`

## Requirements
- R1: After reset, `resp_valid` and `issue_valid` are 0 and the in-flight table is empty.
- R2: A candidate presented with `cand_valid` in cycle t produces `resp_valid`=1 in cycle t+1. If the candidate is accepted, that cycle also shows `resp_issued`=1, `resp_reason`=0, `issue_valid`=1 and `issue_addr` equal to the candidate line, and the line is added to the table.
- R3: A candidate with `l2_present`=1 is rejected with `resp_reason`=1. This check has the highest priority.
- R4: A candidate with `l1_present`=1, and not rejected by R3, is rejected with `resp_reason`=2.
- R5: A candidate with `miss_match`=1, and not rejected by R3 or R4, is rejected with `resp_reason`=3.
- R6: A candidate whose line is already in the in-flight table, and not rejected by R3 to R5, is rejected with `resp_reason`=4.
- R7: When DEPTH entries (default 32) are outstanding, a candidate not rejected by R3 to R6 is rejected with `resp_reason`=5. The table never holds more than DEPTH entries.
- R8: A completion (`done_valid`) removes every table entry equal to `done_addr`. That slot and that line can be issued again from the next cycle on.
- R9: When a candidate and a completion name the same line in the same cycle, the candidate is rejected with `resp_reason`=4, and the entry is still removed.
- R10: A completion for a line that is not in the table leaves the table unchanged.
- R11: With `cand_valid`=0 in cycle t, cycle t+1 shows `resp_valid`=0 and `issue_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | 1 | Candidate present this cycle |
| cand_addr | input | ADDR_W | Candidate line address |
| l2_present | input | 1 | Candidate line found in second-level cache |
| l1_present | input | 1 | Candidate line found in first-level cache |
| miss_match | input | 1 | Candidate line matches an outstanding demand miss |
| done_valid | input | 1 | A line has arrived in a cache |
| done_addr | input | ADDR_W | Line address of that arrival |
| issue_valid | output | 1 | Prefetch request strobe |
| issue_addr | output | ADDR_W | Prefetch request line address |
| resp_valid | output | 1 | Response to the previous cycle's candidate |
| resp_issued | output | 1 | 1 if that candidate was issued |
| resp_reason | output | 3 | 0 issued, 1 L2 hit, 2 L1 hit, 3 demand miss, 4 in flight, 5 table full |

## Verification
The assertions assume that the three lookup inputs describe the candidate of the same cycle and are 0 or 1, never X, whenever `cand_valid` is high. They also assume that a completion names one line. The bench meets these assumptions by driving every input to a known value at the falling edge and holding it through the rising edge. It sweeps all eight combinations of the three lookup flags against empty, partly filled and full tables, and it then runs a long pseudo-random phase over sixteen lines so that duplicates and same-cycle completions occur often.

// File: rtl/pf_filter_pkg.sv
package pf_filter_pkg;

    typedef enum logic [2:0] {
        RSN_ISSUED   = 3'd0,
        RSN_L2HIT    = 3'd1,
        RSN_L1HIT    = 3'd2,
        RSN_DEMAND   = 3'd3,
        RSN_INFLIGHT = 3'd4,
        RSN_FULL     = 3'd5
    } rsn_e;

    typedef enum logic [1:0] {
        OCC_IDLE = 2'd0,
        OCC_PART = 2'd1,
        OCC_CAP  = 2'd2
    } occ_state_e;

endpackage

// File: rtl/pf_track_cam.sv
module pf_track_cam #(
    parameter int ADDR_W = 27,
    parameter int DEPTH  = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] look_addr,
    input  logic              alloc_en,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic              rel_en,
    input  logic [ADDR_W-1:0] rel_addr,
    output logic              look_hit,
    output logic              rel_hit,
    output logic [DEPTH-1:0]  slot_vld
);

    logic [ADDR_W-1:0] slot_addr [DEPTH];
    logic [DEPTH-1:0]  look_m;
    logic [DEPTH-1:0]  rel_m;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign look_m[g] = slot_vld[g] && (slot_addr[g] == look_addr);
        assign rel_m[g]  = slot_vld[g] && (slot_addr[g] == rel_addr);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_vld[g]  <= 1'b0;
                slot_addr[g] <= '0;
            end else if (rel_en && rel_m[g]) begin
                slot_vld[g]  <= 1'b0;
            end else if (alloc_en && (alloc_idx == IDX_W'(g))) begin
                slot_vld[g]  <= 1'b1;
                slot_addr[g] <= alloc_addr;
            end
        end
    end

    assign look_hit = |look_m;
    assign rel_hit  = rel_en && (|rel_m);

endmodule

// File: rtl/pf_slot_pick.sv
module pf_slot_pick #(
    parameter int DEPTH = 32,
    parameter int IDX_W = 5
) (
    input  logic [DEPTH-1:0] slot_vld,
    output logic [IDX_W-1:0] free_idx
);

    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!slot_vld[i]) free_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/pf_occ_fsm.sv
module pf_occ_fsm
    import pf_filter_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grow,
    input  logic             shrink,
    output logic [CNT_W-1:0] occ_cnt,
    output logic             at_cap
);

    localparam logic [CNT_W-1:0] LAST_ONE = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    occ_state_e state_q, state_d;

    // state register and occupancy counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OCC_IDLE;
            occ_cnt <= '0;
        end else begin
            state_q <= state_d;
            occ_cnt <= occ_cnt + CNT_W'(grow) - CNT_W'(shrink);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_IDLE: begin
                if (grow) state_d = (DEPTH == 1) ? OCC_CAP : OCC_PART;
            end
            OCC_PART: begin
                if (grow && !shrink && occ_cnt == LAST_ONE)
                    state_d = OCC_CAP;
                else if (shrink && !grow && occ_cnt == ONE)
                    state_d = OCC_IDLE;
            end
            OCC_CAP: begin
                if (shrink && !grow) state_d = (DEPTH == 1) ? OCC_IDLE : OCC_PART;
            end
            default: state_d = OCC_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        at_cap = (state_q == OCC_CAP);
    end

endmodule

// File: rtl/pf_issue_filter.sv
module pf_issue_filter
    import pf_filter_pkg::*;
#(
    parameter int ADDR_W = 27,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_valid,
    input  logic [ADDR_W-1:0] cand_addr,
    input  logic              l2_present,
    input  logic              l1_present,
    input  logic              miss_match,
    input  logic              done_valid,
    input  logic [ADDR_W-1:0] done_addr,
    output logic              issue_valid,
    output logic [ADDR_W-1:0] issue_addr,
    output logic              resp_valid,
    output logic              resp_issued,
    output logic [2:0]        resp_reason
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             look_hit;
    logic             rel_hit;
    logic [DEPTH-1:0] slot_vld;
    logic [IDX_W-1:0] free_idx;
    logic [CNT_W-1:0] occ_cnt;
    logic             at_cap;
    logic             grant;
    rsn_e             rsn;

    pf_track_cam #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) cam_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_addr (cand_addr),
        .alloc_en  (grant),
        .alloc_idx (free_idx),
        .alloc_addr(cand_addr),
        .rel_en    (done_valid),
        .rel_addr  (done_addr),
        .look_hit  (look_hit),
        .rel_hit   (rel_hit),
        .slot_vld  (slot_vld)
    );

    pf_slot_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) pick_i (
        .slot_vld(slot_vld),
        .free_idx(free_idx)
    );

    pf_occ_fsm #(.DEPTH(DEPTH), .CNT_W(CNT_W)) occ_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .grow   (grant),
        .shrink (rel_hit),
        .occ_cnt(occ_cnt),
        .at_cap (at_cap)
    );

    // Rejection priority: L2, L1, demand miss, in flight, capacity.
    // The in-flight search uses the contents before this cycle's release.
    always_comb begin
        if (l2_present)      rsn = RSN_L2HIT;
        else if (l1_present) rsn = RSN_L1HIT;
        else if (miss_match) rsn = RSN_DEMAND;
        else if (look_hit)   rsn = RSN_INFLIGHT;
        else if (at_cap)     rsn = RSN_FULL;
        else                 rsn = RSN_ISSUED;
        grant = cand_valid && (rsn == RSN_ISSUED);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_valid <= 1'b0;
            issue_addr  <= '0;
            resp_valid  <= 1'b0;
            resp_issued <= 1'b0;
            resp_reason <= 3'd0;
        end else begin
            issue_valid <= grant;
            resp_valid  <= cand_valid;
            resp_issued <= grant;
            resp_reason <= cand_valid ? rsn : RSN_ISSUED;
            if (grant) issue_addr <= cand_addr;
        end
    end

endmodule

module pf_issue_filter_chk #(
    parameter int ADDR_W = 27,
    parameter int DEPTH  = 32,
    parameter int CNT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cand_valid,
    input logic [ADDR_W-1:0] cand_addr,
    input logic              l2_present,
    input logic              l1_present,
    input logic              miss_match,
    input logic              issue_valid,
    input logic [ADDR_W-1:0] issue_addr,
    input logic              resp_valid,
    input logic              resp_issued,
    input logic [2:0]        resp_reason,
    input logic [CNT_W-1:0]  occ_cnt,
    input logic [DEPTH-1:0]  slot_vld,
    input logic              at_cap
);

    a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |=> resp_valid);
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cand_valid |=> (!resp_valid && !issue_valid));
    a_r2_issue_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid == (resp_valid && resp_issued));
    a_r2_issue_addr: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |=> (!issue_valid || issue_addr == $past(cand_addr)));
    a_r3_l2_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && l2_present) |=> (!issue_valid && resp_reason == 3'd1));
    a_r5_miss_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && miss_match && !l1_present && !l2_present) |=> (resp_reason == 3'd3));
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_cnt <= CNT_W'(DEPTH)) && (32'(occ_cnt) == $countones(slot_vld)));
    a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && at_cap) |=> !issue_valid);
    a_r7_cap_state: assert property (@(posedge clk) disable iff (!rst_n)
        at_cap == (&slot_vld));

endmodule

bind pf_issue_filter pf_issue_filter_chk #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cand_valid (cand_valid),
    .cand_addr  (cand_addr),
    .l2_present (l2_present),
    .l1_present (l1_present),
    .miss_match (miss_match),
    .issue_valid(issue_valid),
    .issue_addr (issue_addr),
    .resp_valid (resp_valid),
    .resp_issued(resp_issued),
    .resp_reason(resp_reason),
    .occ_cnt    (occ_cnt),
    .slot_vld   (slot_vld),
    .at_cap     (at_cap)
);

// File: tb/pf_issue_filter_tb.sv
module pf_issue_filter_tb_top;

    localparam int AW = 27;
    localparam int DP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cand_valid = 1'b0;
    logic [AW-1:0] cand_addr = '0;
    logic          l2_present = 1'b0;
    logic          l1_present = 1'b0;
    logic          miss_match = 1'b0;
    logic          done_valid = 1'b0;
    logic [AW-1:0] done_addr = '0;
    logic          issue_valid;
    logic [AW-1:0] issue_addr;
    logic          resp_valid;
    logic          resp_issued;
    logic [2:0]    resp_reason;

    int checks = 0;
    int errors = 0;
    logic          m_v [DP];
    logic [AW-1:0] m_a [DP];
    logic [31:0]   rng = 32'h1234_5678;

    always #2 clk = ~clk;

    pf_issue_filter #(.ADDR_W(AW), .DEPTH(DP)) dut_i (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int m_count();
        int n = 0;
        for (int i = 0; i < DP; i++) if (m_v[i]) n++;
        return n;
    endfunction

    function automatic logic m_has(input logic [AW-1:0] a);
        for (int i = 0; i < DP; i++) if (m_v[i] && m_a[i] == a) return 1'b1;
        return 1'b0;
    endfunction

    // One cycle: drive, clock, sample, compare against the reference model.
    task automatic step(input logic cv, input logic [AW-1:0] ca,
                        input logic f1, input logic f2, input logic fm,
                        input logic dv, input logic [AW-1:0] da,
                        input string tag);
        logic [2:0] er;
        string rq;
        if (f2)                   er = 3'd1;
        else if (f1)              er = 3'd2;
        else if (fm)              er = 3'd3;
        else if (m_has(ca))       er = 3'd4;
        else if (m_count() == DP) er = 3'd5;
        else                      er = 3'd0;
        case (er)
            3'd1: rq = "R3";
            3'd2: rq = "R4";
            3'd3: rq = "R5";
            3'd4: rq = "R6";
            3'd5: rq = "R7";
            default: rq = "R2";
        endcase
        if (!cv) rq = "R11";
        if (tag != "") rq = tag;
        @(negedge clk);
        cand_valid = cv; cand_addr = ca;
        l1_present = f1; l2_present = f2; miss_match = fm;
        done_valid = dv; done_addr = da;
        @(posedge clk);
        #1;
        chk(rq, "resp_valid", 32'(resp_valid), 32'(cv));
        if (cv) begin
            chk(rq, "resp_reason", 32'(resp_reason), 32'(er));
            chk(rq, "resp_issued", 32'(resp_issued), 32'(er == 3'd0));
            chk(rq, "issue_valid", 32'(issue_valid), 32'(er == 3'd0));
            if (er == 3'd0) chk(rq, "issue_addr", 32'(issue_addr), 32'(ca));
        end else begin
            chk(rq, "issue_valid", 32'(issue_valid), 32'h0);
        end
        if (dv) for (int i = 0; i < DP; i++) if (m_v[i] && m_a[i] == da) m_v[i] = 1'b0;
        if (cv && er == 3'd0) begin
            for (int i = 0; i < DP; i++) begin
                if (!m_v[i]) begin
                    m_v[i] = 1'b1; m_a[i] = ca; break;
                end
            end
        end
    endtask

    task automatic drain();
        for (int i = 0; i < DP; i++)
            if (m_v[i]) step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, m_a[i], "R8");
    endtask

    initial begin
        for (int i = 0; i < DP; i++) begin m_v[i] = 1'b0; m_a[i] = '0; end
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "resp_valid in reset", 32'(resp_valid), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", "resp_valid after reset", 32'(resp_valid), 32'h0);
        chk("R1", "issue_valid after reset", 32'(issue_valid), 32'h0);

        // R2 basic issue, R6 duplicate
        step(1'b1, 27'h100, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R2");
        step(1'b1, 27'h100, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R6");
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R11");
        drain();

        // Exhaustive flag sweep; the table fills along the way (R3..R7)
        for (int a = 0; a < 12; a++)
            for (int f = 0; f < 8; f++)
                step(1'b1, AW'(27'h40 + a), f[0], f[1], f[2], 1'b0, '0, "");

        // Full table: capacity reject, and priority of lookup flags over it
        step(1'b1, 27'h7ff, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R7");
        step(1'b1, 27'h7ff, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R3");
        step(1'b1, 27'h7ff, 1'b0, 1'b0, 1'b1, 1'b0, '0, "R5");
        // R10: completion for an absent line leaves the table full
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 27'h5555, "R10");
        step(1'b1, 27'h7ff, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R10");
        // R8: release one entry, then the slot and line are reusable
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 27'h43, "R8");
        step(1'b1, 27'h43, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R8");
        // R9: candidate and completion of the same line together
        step(1'b1, 27'h44, 1'b0, 1'b0, 1'b0, 1'b1, 27'h44, "R9");
        step(1'b1, 27'h44, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R9");
        drain();

        // Pseudo-random phase over sixteen lines
        for (int n = 0; n < 4000; n++) begin
            rng = rng ^ (rng << 13);
            rng = rng ^ (rng >> 17);
            rng = rng ^ (rng << 5);
            step(rng[20] | rng[21], AW'(rng[27:24]),
                 rng[7:4] == 4'h0, rng[3:0] == 4'h0, rng[11:8] == 4'h0,
                 rng[12], AW'(rng[19:16]), "");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule